// File: doc/BRIEF.md
# Phase Interpolator Step Controller

This block turns relative phase-shift requests into an absolute code for a transmit phase interpolator. A request consists of a strobe, a direction bit and a 4-bit step size. The block keeps a 7-bit accumulated phase. Each accepted request moves that phase up or down, and the phase wraps modulo 128.

In register mode, which is the default, each new phase code is committed through a write-only configuration-port transaction. The block raises enable and write-enable for one cycle, with a fixed address and the phase in the write data. It then waits for the ready handshake and answers with a one-cycle done pulse. In port mode, chosen by parameter, the block emits a single cycle with the interpolator enabled and a 5-bit step word, then pulses done. The static select, override and power-down controls follow the chosen mode.

Top module: `pi_step_ctrl`

## Requirements
- R1: After reset, the phase code is 0 and done, configuration enable, write-enable and interpolator enable are all 0.
- R2: Only a 0-to-1 transition of the strobe is a request. A strobe held high for many cycles produces exactly one shift and one write.
- R3: A direction of 1 adds the step size (0..15) to the phase and a direction of 0 subtracts it, both modulo 128. The phase output changes in the cycle after the strobe edge is sampled and holds otherwise.
- R4: In register mode, in the cycle after an accepted edge, configuration enable and write-enable are both 1 for exactly one cycle. In that cycle the address is CFG_ADDR (default 0x09A) and the write data carries the new phase in bits 6:0, with bits 15:7 zero.
- R5: Done is 1 for exactly one cycle, the cycle after ready is sampled high while a write is pending. Ready while nothing is pending has no effect.
- R6: Strobe edges that arrive while a write is pending are dropped: the phase does not move and no further write is issued.
- R7: In register mode, select is 1, override is 1, power-down is 0, interpolator enable is 0 and the step word is 0.
- R8: In port mode, an accepted edge gives one cycle with interpolator enable 1 and the step word equal to {direction, step} (direction in bit 4). Done follows in the next cycle. Override is 0, select is 1, power-down is 0, and configuration enable stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_strobe | input | 1 | Shift request; its rising edge is captured |
| req_up | input | 1 | 1 = advance phase, 0 = retard phase |
| req_step | input | 4 | Step magnitude |
| shift_done | output | 1 | One-cycle pulse when a shift is complete |
| phase_code | output | 7 | Accumulated phase |
| pi_enable | output | 1 | Interpolator step enable (port mode) |
| pi_override | output | 1 | Register-path override of the interpolator |
| pi_select | output | 1 | Interpolator controller select |
| pi_powerdown | output | 1 | Interpolator power-down |
| pi_step_word | output | 5 | Direction and magnitude of a port-mode step |
| cfg_addr | output | 9 | Configuration-port address |
| cfg_en | output | 1 | Configuration-port transaction enable |
| cfg_we | output | 1 | Configuration-port write enable |
| cfg_wdata | output | 16 | Configuration-port write data |
| cfg_ready | input | 1 | Configuration-port transaction complete |

## Verification
Two events can fall in the same cycle: the done pulse that closes one write, and the acceptance of the next strobe edge. The bench raises a new strobe in the very cycle it observes done. It then expects a fresh enable and write-enable one cycle later, carrying the correctly accumulated phase. It also raises a strobe in the middle of a pending write to show that the edge is lost and not queued. Every step size is swept in both directions with ready latencies of 0 to 3 cycles, and the phase is compared against modulo-128 arithmetic.

// File: rtl/pi_step_pkg.sv
package pi_step_pkg;

    localparam int PHASE_W = 7;
    localparam int STEP_W  = 4;
    localparam int ADDR_W  = 9;
    localparam int DATA_W  = 16;
    localparam int WORD_W  = STEP_W + 1;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_PSTEP
    } seq_state_e;

    typedef struct packed {
        logic              up;
        logic [STEP_W-1:0] step;
    } step_req_t;

    function automatic logic [PHASE_W-1:0] apply_step(
        input logic [PHASE_W-1:0] cur,
        input step_req_t          r
    );
        logic [PHASE_W-1:0] delta;
        delta = PHASE_W'(r.step);
        return r.up ? cur + delta : cur - delta;
    endfunction

endpackage

// File: rtl/pi_req_capture.sv
module pi_req_capture (
    input  logic clk,
    input  logic rst,
    input  logic strobe,
    output logic rise
);
    logic strobe_q;

    always_ff @(posedge clk) begin
        if (rst) strobe_q <= 1'b0;
        else     strobe_q <= strobe;
    end

    assign rise = strobe & ~strobe_q;

    // R2: an edge can never be reported on two consecutive cycles
    a_r2_single_edge: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);

endmodule

// File: rtl/pi_phase_acc.sv
module pi_phase_acc
    import pi_step_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               accept,
    input  step_req_t          req,
    output logic [PHASE_W-1:0] phase
);
    always_ff @(posedge clk) begin
        if (rst)         phase <= '0;
        else if (accept) phase <= apply_step(phase, req);
    end

    // R3: the phase is held whenever no request is accepted
    a_r3_hold: assert property (@(posedge clk) disable iff (rst)
        !accept |=> $stable(phase));

endmodule

// File: rtl/pi_seq.sv
module pi_seq
    import pi_step_pkg::*;
#(
    parameter bit REG_MODE = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rise,
    input  step_req_t         req,
    input  logic              cfg_ready,
    output logic              accept,
    output logic              cfg_pulse,
    output logic              pstep_en,
    output logic [WORD_W-1:0] step_word,
    output logic              done
);
    seq_state_e state;

    assign accept = (state == ST_IDLE) && rise;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cfg_pulse <= 1'b0;
            pstep_en  <= 1'b0;
            step_word <= '0;
            done      <= 1'b0;
        end else begin
            cfg_pulse <= 1'b0;
            pstep_en  <= 1'b0;
            step_word <= '0;
            done      <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (rise) begin
                        if (REG_MODE) begin
                            cfg_pulse <= 1'b1;
                            state     <= ST_WAIT;
                        end else begin
                            pstep_en  <= 1'b1;
                            step_word <= {req.up, req.step};
                            state     <= ST_PSTEP;
                        end
                    end
                end
                ST_WAIT: begin
                    if (cfg_ready) begin
                        done  <= 1'b1;
                        state <= ST_IDLE;
                    end
                end
                ST_PSTEP: begin
                    done  <= 1'b1;
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R4: configuration strobe lasts one cycle
    a_r4_cfg_one_cycle: assert property (@(posedge clk) disable iff (rst)
        cfg_pulse |=> !cfg_pulse);

    // R5: done lasts one cycle
    a_r5_done_one_cycle: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R5: in register mode done only follows a sampled ready
    a_r5_done_after_ready: assert property (@(posedge clk) disable iff (rst)
        (done && REG_MODE) |-> $past(cfg_ready));

    // R8: a port-mode step is followed by done
    a_r8_step_then_done: assert property (@(posedge clk) disable iff (rst)
        pstep_en |=> done);

endmodule

// File: rtl/pi_step_ctrl.sv
module pi_step_ctrl
    import pi_step_pkg::*;
#(
    parameter bit               REG_MODE = 1'b1,
    parameter logic [ADDR_W-1:0] CFG_ADDR = 9'h09A
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_strobe,
    input  logic               req_up,
    input  logic [STEP_W-1:0]  req_step,
    output logic               shift_done,
    output logic [PHASE_W-1:0] phase_code,
    output logic               pi_enable,
    output logic               pi_override,
    output logic               pi_select,
    output logic               pi_powerdown,
    output logic [WORD_W-1:0]  pi_step_word,
    output logic [ADDR_W-1:0]  cfg_addr,
    output logic               cfg_en,
    output logic               cfg_we,
    output logic [DATA_W-1:0]  cfg_wdata,
    input  logic               cfg_ready
);
    localparam int PAD_W = DATA_W - PHASE_W;

    step_req_t req;
    logic      rise;
    logic      accept;
    logic      cfg_pulse;

    assign req.up   = req_up;
    assign req.step = req_step;

    pi_req_capture u_cap (
        .clk    (clk),
        .rst    (rst),
        .strobe (req_strobe),
        .rise   (rise)
    );

    pi_seq #(.REG_MODE(REG_MODE)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .rise      (rise),
        .req       (req),
        .cfg_ready (cfg_ready),
        .accept    (accept),
        .cfg_pulse (cfg_pulse),
        .pstep_en  (pi_enable),
        .step_word (pi_step_word),
        .done      (shift_done)
    );

    pi_phase_acc u_acc (
        .clk    (clk),
        .rst    (rst),
        .accept (accept),
        .req    (req),
        .phase  (phase_code)
    );

    assign cfg_en       = cfg_pulse;
    assign cfg_we       = cfg_pulse;
    assign cfg_addr     = REG_MODE ? CFG_ADDR : '0;
    assign cfg_wdata    = {{PAD_W{1'b0}}, phase_code};
    assign pi_override  = REG_MODE;
    assign pi_select    = 1'b1;
    assign pi_powerdown = 1'b0;

    // R3: the phase only moves together with a write or a port step
    a_r3_move_with_commit: assert property (@(posedge clk) disable iff (rst)
        !$stable(phase_code) |-> (cfg_en || pi_enable));

    // R6: no second write before the pending one is answered
    a_r6_no_stacked_write: assert property (@(posedge clk) disable iff (rst)
        (cfg_en && !cfg_ready) |=> !cfg_en);

endmodule

// File: tb/sim_pi_step_ctrl.sv
module sim_pi_step_ctrl;
    localparam int PERIOD = 10;
    localparam int WD_CYCLES = 20000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(PERIOD/2) clk = ~clk;

    logic       strobe = 0, up = 0, ready = 0;
    logic [3:0] step = 0;
    logic       done, en, we, pien, ovr, sel, pd;
    logic [6:0] phase;
    logic [4:0] sword;
    logic [8:0] addr;
    logic [15:0] wdata;

    logic       p_strobe = 0, p_up = 0;
    logic [3:0] p_step = 0;
    logic       p_done, p_en, p_we, p_pien, p_ovr, p_sel, p_pd;
    logic [6:0] p_phase;
    logic [4:0] p_sword;
    logic [8:0] p_addr;
    logic [15:0] p_wdata;

    pi_step_ctrl u0 (
        .clk(clk), .rst(rst), .req_strobe(strobe), .req_up(up), .req_step(step),
        .shift_done(done), .phase_code(phase), .pi_enable(pien), .pi_override(ovr),
        .pi_select(sel), .pi_powerdown(pd), .pi_step_word(sword), .cfg_addr(addr),
        .cfg_en(en), .cfg_we(we), .cfg_wdata(wdata), .cfg_ready(ready)
    );

    pi_step_ctrl #(.REG_MODE(1'b0)) u1 (
        .clk(clk), .rst(rst), .req_strobe(p_strobe), .req_up(p_up), .req_step(p_step),
        .shift_done(p_done), .phase_code(p_phase), .pi_enable(p_pien), .pi_override(p_ovr),
        .pi_select(p_sel), .pi_powerdown(p_pd), .pi_step_word(p_sword), .cfg_addr(p_addr),
        .cfg_en(p_en), .cfg_we(p_we), .cfg_wdata(p_wdata), .cfg_ready(1'b0)
    );

    int checks = 0;
    int errors = 0;
    logic [6:0] model = 0;
    logic [6:0] pmodel = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_shift(input bit d, input int s, input int delay,
                            input bit keep, input bit intrude, input bit quick);
        strobe = 1; up = d; step = s[3:0];
        model = d ? model + 7'(s) : model - 7'(s);
        @(negedge clk);
        chk(en == 1, "R4 en", int'(en), 1);
        chk(we == 1, "R4 we", int'(we), 1);
        chk(addr == 9'h09A, "R4 addr", int'(addr), 'h9A);
        chk(wdata == {9'b0, model}, "R4 wdata", int'(wdata), int'(model));
        chk(phase == model, "R3 phase", int'(phase), int'(model));
        chk(done == 0, "R5 early done", int'(done), 0);
        if (!keep) strobe = 0;
        for (int i = 0; i < delay; i++) begin
            if (intrude && i == 0) begin strobe = 1; up = ~d; step = 4'd9; end
            if (intrude && i == 1) strobe = 0;
            @(negedge clk);
            chk(en == 0, "R6 en while pending", int'(en), 0);
            chk(done == 0, "R5 done before ready", int'(done), 0);
            chk(phase == model, "R6 phase while pending", int'(phase), int'(model));
        end
        ready = 1;
        @(negedge clk);
        ready = 0;
        chk(done == 1, "R5 done", int'(done), 1);
        if (!quick || keep) begin
            @(negedge clk);
            chk(done == 0, "R5 done width", int'(done), 0);
            chk(en == 0, "R4 en width", int'(en), 0);
            if (keep) begin
                repeat (2) begin
                    @(negedge clk);
                    chk(en == 0, "R2 held strobe", int'(en), 0);
                    chk(phase == model, "R2 held phase", int'(phase), int'(model));
                end
                strobe = 0;
                @(negedge clk);
            end
        end
    endtask

    initial begin
        #(WD_CYCLES * PERIOD);
        errors++;
        $display("FAIL watchdog R1 actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk(phase == 0, "R1 phase", int'(phase), 0);
        chk(done == 0 && en == 0 && we == 0 && pien == 0, "R1 pulses", int'({done, en, we, pien}), 0);
        // R7 static controls in register mode
        chk(sel == 1 && ovr == 1 && pd == 0, "R7 static", int'({sel, ovr, pd}), 6);
        chk(sword == 0 && pien == 0, "R7 step word", int'(sword), 0);

        // R5 ready while idle has no effect
        ready = 1;
        @(negedge clk);
        ready = 0;
        chk(done == 0, "R5 idle ready", int'(done), 0);
        chk(phase == 0, "R5 idle ready phase", int'(phase), 0);

        // R3 sweep of every step in both directions, varied ready latency;
        // quick completions start the next request in the done cycle
        for (int d = 1; d >= 0; d--) begin
            for (int s = 0; s < 16; s++) begin
                do_shift(d[0], s, (s == 7) ? 3 : (s % 4), 1'b0, s == 7, (s % 5) == 0);
            end
        end
        @(negedge clk);

        // R3 explicit wrap upward past 127 and downward past 0
        while (model < 7'd120) do_shift(1'b1, 15, 0, 1'b0, 1'b0, 1'b0);
        do_shift(1'b1, 15, 1, 1'b0, 1'b0, 1'b0);
        while (model > 7'd5) do_shift(1'b0, 15, 0, 1'b0, 1'b0, 1'b0);
        do_shift(1'b0, 12, 2, 1'b0, 1'b0, 1'b0);

        // R2 strobe held high across the whole transaction
        do_shift(1'b1, 3, 1, 1'b1, 1'b0, 1'b0);
        do_shift(1'b0, 11, 0, 1'b1, 1'b0, 1'b0);

        // R8 port mode
        chk(p_ovr == 0 && p_sel == 1 && p_pd == 0, "R8 static", int'({p_sel, p_ovr, p_pd}), 4);
        for (int k = 0; k < 6; k++) begin
            bit pd_up;
            int ps;
            pd_up = k[0];
            ps = 3 + 5 * k;
            ps = ps % 16;
            p_strobe = 1; p_up = pd_up; p_step = ps[3:0];
            pmodel = pd_up ? pmodel + 7'(ps) : pmodel - 7'(ps);
            @(negedge clk);
            p_strobe = 0;
            chk(p_pien == 1, "R8 enable", int'(p_pien), 1);
            chk(p_sword == {pd_up, ps[3:0]}, "R8 step word", int'(p_sword), int'({pd_up, ps[3:0]}));
            chk(p_phase == pmodel, "R8 phase", int'(p_phase), int'(pmodel));
            chk(p_en == 0 && p_we == 0, "R8 no cfg write", int'({p_en, p_we}), 0);
            chk(p_done == 0, "R8 early done", int'(p_done), 0);
            @(negedge clk);
            chk(p_pien == 0 && p_sword == 0, "R8 step width", int'({p_pien, p_sword}), 0);
            chk(p_done == 1, "R8 done", int'(p_done), 1);
            @(negedge clk);
            chk(p_done == 0, "R8 done width", int'(p_done), 0);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule